// File: doc/BRIEF.md
# Prescaled 8-bit PWM Generator

A single-channel pulse-width modulator configured through one 32-bit control word. The word carries an enable flag, a prescale value, an 8-bit duty value and a force-full flag. A prescaler divides the input clock by (SCALE+1). Each prescaler tick advances an 8-bit period counter, so one output period lasts 256 x (SCALE+1) clocks. The output is high from the start of each period until the counter reaches the duty value. Setting the force-full flag holds the output high for the whole period.

The register is written through a synchronous write port, and its current contents can always be read back. A write abandons the running period and starts a fresh one with the new settings. A write that clears the enable flag drops the output low in the next cycle, partway through the period if need be.

Top module: `pwm_prescaled`

## Requirements
- R1: After reset the block is disabled, `pwm_out` is low and `rd_data` reads zero.
- R2: While enabled, the period counter advances once every SCALE+1 clocks, so the output repeats every 256 x (SCALE+1) clocks. SCALE is held in bits 12:0 of the control word.
- R3: The output is high from each counter wrap to zero until the counter equals DUTY, giving a high time of DUTY x (SCALE+1) clocks per period. DUTY is held in bits 23:16.
- R4: With DUTY equal to 0 and the force-full flag clear, an enabled output stays low.
- R5: With the force-full flag (bit 24) set, an enabled output stays high continuously, whatever the value of bits 23:16.
- R6: Writing a word with the enable flag (bit 31) clear drives `pwm_out` low in the cycle after the write, even partway through a period.
- R7: Any write resets the prescaler and the period counter. The cycle after a write that enables the block therefore begins a complete new period, which is high when DUTY is nonzero.
- R8: `rd_data` returns the stored enable flag, force-full flag, DUTY and SCALE at bit positions 31, 24, 23:16 and 12:0. Bits 30:25 and 15:13 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, sampled on the rising clock edge |
| wr_data | input | 32 | Control word to store |
| rd_data | output | 32 | Stored control word, reserved bits zero |
| pwm_out | output | 1 | PWM output |

## Verification
The assertions assume that `wr_en` and `wr_data` are free of X once reset has been released. They also assume that the control word changes only through the write port. Because of that second assumption, a check that the counter holds or steps can be tied to the SCALE value seen on `rd_data`. The bench drives only known values, raises `wr_en` for exactly one cycle per write, and holds the port idle between writes for as long as the expected waveform runs.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int WORD_W   = 32;
  localparam int SCALE_W  = 13;
  localparam int DUTY_W   = 8;
  localparam int EN_BIT   = 31;
  localparam int FULL_BIT = 24;
  localparam int DUTY_LSB = 16;

  function automatic logic [WORD_W-1:0] pack_word(
    input logic              en,
    input logic              full,
    input logic [DUTY_W-1:0] duty,
    input logic [SCALE_W-1:0] scale
  );
    logic [WORD_W-1:0] w;
    w = '0;
    w[EN_BIT]                    = en;
    w[FULL_BIT]                  = full;
    w[DUTY_LSB +: DUTY_W]        = duty;
    w[SCALE_W-1:0]               = scale;
    return w;
  endfunction
endpackage

// File: rtl/pwm_ctrl_reg.sv
module pwm_ctrl_reg
  import pwm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [WORD_W-1:0]  wr_data,
  output logic               en_q,
  output logic               full_q,
  output logic [DUTY_W-1:0]  duty_q,
  output logic [SCALE_W-1:0] scale_q
);
  logic               en_d;
  logic               full_d;
  logic [DUTY_W-1:0]  duty_d;
  logic [SCALE_W-1:0] scale_d;
  logic               unused_rsvd;

  assign unused_rsvd = ^{wr_data[WORD_W-2:FULL_BIT+1], wr_data[DUTY_LSB-1:SCALE_W]};

  always_comb begin
    en_d    = en_q;
    full_d  = full_q;
    duty_d  = duty_q;
    scale_d = scale_q;
    if (wr_en) begin
      en_d    = wr_data[EN_BIT];
      full_d  = wr_data[FULL_BIT];
      duty_d  = wr_data[DUTY_LSB +: DUTY_W];
      scale_d = wr_data[SCALE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      full_q  <= 1'b0;
      duty_q  <= '0;
      scale_q <= '0;
    end else begin
      en_q    <= en_d;
      full_q  <= full_d;
      duty_q  <= duty_d;
      scale_q <= scale_d;
    end
  end
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int SCALE_W = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               restart,
  input  logic [SCALE_W-1:0] scale,
  output logic [SCALE_W-1:0] presc_q,
  output logic               tick
);
  logic [SCALE_W-1:0] presc_d;
  logic               clr;

  assign clr  = !en || restart;
  assign tick = en && !restart && (presc_q == scale);

  always_comb begin
    if (clr || tick) presc_d = '0;
    else             presc_d = presc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) presc_q <= '0;
    else        presc_q <= presc_d;
  end
endmodule

// File: rtl/pwm_period_cnt.sv
module pwm_period_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic             tick,
  input  logic             full,
  input  logic [CNT_W-1:0] duty,
  output logic [CNT_W-1:0] cnt_q,
  output logic             pwm_out
);
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;

  assign cnt_ce = tick;

  always_comb begin
    if (!en || restart) cnt_d = '0;
    else if (cnt_ce)    cnt_d = cnt_q + 1'b1;
    else                cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign pwm_out = en && (full || (cnt_q < duty));
endmodule

// File: rtl/pwm_prescaled.sv
module pwm_prescaled
  import pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic              pwm_out
);
  logic               en_q;
  logic               full_q;
  logic [DUTY_W-1:0]  duty_q;
  logic [SCALE_W-1:0] scale_q;
  logic [SCALE_W-1:0] presc_q;
  logic [DUTY_W-1:0]  cnt_q;
  logic               tick;

  pwm_ctrl_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .en_q    (en_q),
    .full_q  (full_q),
    .duty_q  (duty_q),
    .scale_q (scale_q)
  );

  pwm_prescaler #(.SCALE_W(SCALE_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en_q),
    .restart (wr_en),
    .scale   (scale_q),
    .presc_q (presc_q),
    .tick    (tick)
  );

  pwm_period_cnt #(.CNT_W(DUTY_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en_q),
    .restart (wr_en),
    .tick    (tick),
    .full    (full_q),
    .duty    (duty_q),
    .cnt_q   (cnt_q),
    .pwm_out (pwm_out)
  );

  assign rd_data = pack_word(en_q, full_q, duty_q, scale_q);
endmodule

// File: rtl/pwm_prescaled_chk.sv
module pwm_prescaled_chk
  import pwm_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [WORD_W-1:0]  rd_data,
  input logic               pwm_out,
  input logic [SCALE_W-1:0] presc_q,
  input logic [DUTY_W-1:0]  cnt_q
);
  logic               c_en;
  logic               c_full;
  logic [DUTY_W-1:0]  c_duty;
  logic [SCALE_W-1:0] c_scale;

  assign c_en    = rd_data[EN_BIT];
  assign c_full  = rd_data[FULL_BIT];
  assign c_duty  = rd_data[DUTY_LSB +: DUTY_W];
  assign c_scale = rd_data[SCALE_W-1:0];

  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !c_en |-> !pwm_out); // R6
  AST_FULL_DUTY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (c_en && c_full) |-> pwm_out); // R5
  AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (c_en && !c_full && c_duty == '0) |-> !pwm_out); // R4
  AST_WRITE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (presc_q == '0 && cnt_q == '0)); // R7
  AST_CNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (c_en && !wr_en && presc_q != c_scale) |=> $stable(cnt_q)); // R2
  AST_CNT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (c_en && !wr_en && presc_q == c_scale) |=> (cnt_q == DUTY_W'($past(cnt_q) + 1'b1))); // R2
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[WORD_W-2:FULL_BIT+1] == '0) && (rd_data[DUTY_LSB-1:SCALE_W] == '0)); // R8
endmodule

bind pwm_prescaled pwm_prescaled_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .rd_data (rd_data),
  .pwm_out (pwm_out),
  .presc_q (presc_q),
  .cnt_q   (cnt_q)
);

// File: tb/pwm_prescaled_test.sv
module pwm_prescaled_test;
  import pwm_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic              clk;
  logic              rst_n;
  logic              wr_en;
  logic [WORD_W-1:0] wr_data;
  logic [WORD_W-1:0] rd_data;
  logic              pwm_out;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  bit    exp_q[$];
  string tag_q[$];
  int    sample_idx[$];

  pwm_prescaled uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .pwm_out (pwm_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [WORD_W-1:0] mk(input bit en, input bit full,
                                           input int duty, input int scale);
    logic [WORD_W-1:0] w;
    w = '0;
    w[31]    = en;
    w[24]    = full;
    w[23:16] = duty[7:0];
    w[12:0]  = scale[12:0];
    return w;
  endfunction

  // Monitor: compares each expected output sample against the design.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      bit    e;
      string t;
      int    i;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      i = sample_idx.pop_front();
      checks++;
      if (pwm_out !== e) begin
        errors++;
        $display("FAIL %s: pwm_out at sample %0d actual=%b expected=%b", t, i, pwm_out, e);
      end
    end
  end

  task automatic check_word(input string tag, input logic [WORD_W-1:0] act,
                            input logic [WORD_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: one write, then push n expected output samples from the model.
  task automatic do_write(input logic [WORD_W-1:0] w, input int n, input string tag);
    bit en, full;
    int duty, s1;
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = w;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    en   = w[31];
    full = w[24];
    duty = int'(w[23:16]);
    s1   = int'(w[12:0]) + 1;
    for (int t = 0; t < n; t++) begin
      int step;
      step = (t / s1) % 256;
      exp_q.push_back(en && (full || step < duty));
      tag_q.push_back(tag);
      sample_idx.push_back(t);
    end
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check_word("R1 rd_data", rd_data, '0);
    check_word("R1 pwm_out", {31'b0, pwm_out}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check_word("R1 pwm_out after release", {31'b0, pwm_out}, '0);

    // R2 R3: no prescale, duty 64, more than one period
    do_write(mk(1, 0, 64, 0), 300, "R3 duty64 scale0");
    // R2: prescale by 3, duty 10, over one full period
    do_write(mk(1, 0, 10, 2), 800, "R2 duty10 scale2");
    // R3: duty 255 gives one low step per period
    do_write(mk(1, 0, 255, 1), 520, "R3 duty255 scale1");
    // R4: zero duty stays low
    do_write(mk(1, 0, 0, 0), 300, "R4 duty0");
    // R5: force full with arbitrary duty bits
    do_write(mk(1, 1, 5, 0), 300, "R5 full duty");
    // R7: write while running, abandoning the period midway
    do_write(mk(1, 0, 200, 0), 100, "R7 before restart");
    do_write(mk(1, 0, 30, 1), 200, "R7 restart midperiod");
    // R6: disable mid-period drops output next cycle
    do_write(mk(0, 0, 30, 1), 50, "R6 disable");
    // R7: re-enable starts a full fresh period
    do_write(mk(1, 0, 3, 4), 40, "R7 enable fresh period");
    // R8: readback with reserved bits set
    do_write(32'hFFFF_FFFF, 20, "R5 all ones");
    @(negedge clk);
    check_word("R8 readback reserved zero", rd_data, 32'h81FF_1FFF);
    do_write(mk(1, 0, 8'hA5, 13'h1234), 4, "R3 readback cfg");
    @(negedge clk);
    check_word("R8 readback fields", rd_data, 32'h80A5_1234);
    // R6: disable while full duty
    do_write(mk(1, 1, 0, 0), 10, "R5 full before off");
    do_write(mk(0, 1, 0, 0), 10, "R6 disable from full");

    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule